// File: doc/BRIEF.md
# Packet Buffer Allocation MMU

This block hands out and takes back pages from a small pool of fixed-size packet pages that the transmit and the receive paths share. It keeps a bitmap of used pages and three queues of page numbers: pages waiting to be sent, received pages waiting for the host, and sent pages waiting for the host to retire them. The host drives it with 3-bit commands. Each command comes with a strobe and the page number the host is working on. A receive engine asks for a page with a one-cycle request, and a transmit engine drains the transmit queue with a done pulse. The page data, the MAC and the frame check are outside this block.

Four events are kept in an 8-bit status byte: allocation done, frame received, frame sent and transmit queue idle. An 8-bit mask selects which of these drive the interrupt line, and an acknowledge write clears selected bits. The block accepts one command per cycle and never reports busy. If a transmit allocation fails because the pool is full, the block records it. The allocation then completes by itself the first time a page becomes free.

Same-cycle order: the receive request is checked against the used pages at the start of the cycle. After that come the transmit done, the command, any pending allocation and the status update.

Top module: `pkt_mmu`

## Requirements
- R1: Every allocation takes the lowest-numbered free page. When every page is in use, `alloc_result` reads 0x80.
- R2: Command 1 (allocate for transmit) first sets `alloc_result` to 0x80 and clears status bit 3 (allocation). If a page is free, the cycle ends with `alloc_result` equal to that page and bit 3 set.
- R3: While `alloc_result` is 0x80 after a failed command 1, the first release of any page makes `alloc_result` take the lowest free page and sets status bit 3. No new command is needed.
- R4: A receive request gets `rx_grant` and `rx_page` in the same cycle, combinationally, when a page is free. The page goes to the tail of the receive queue and status bit 0 (receive) is set. With no free page the request is dropped and `rx_page` reads 0x80.
- R5: Command 3 removes the head of the receive queue and moves the remaining entries forward. Command 4 does the same and also frees the head page. After either command, status bit 0 is 1 if entries remain and 0 if the queue is empty.
- R6: Command 6 adds `cmd_pnum` to the tail of the transmit queue. The command is ignored when the queue holds NUM_PAGES entries or when `cmd_pnum` is not below NUM_PAGES. `tx_valid` and `tx_page` show the head of the queue. Command 7 empties both the transmit queue and the completion queue.
- R7: On `tx_done` with `auto_release` high, the head page is removed from the transmit queue and freed. With `auto_release` low, the head page is moved to the completion queue instead, but only if that queue holds fewer than NUM_PAGES entries; otherwise it is dropped.
- R8: Status bit 2 (transmit idle) is set in any cycle that ends with the transmit queue empty. Status bit 1 (sent) is set in any cycle that ends with the completion queue not empty.
- R9: `irq` is high when `int_status` AND `int_mask` is nonzero. A mask write loads `int_mask` from `mask_data`.
- R10: An acknowledge write clears only the status bits that are set in both `ack_data` and 0xD6. If `ack_data` bit 1 is set, the head of the completion queue is also removed.
- R11: `rx_head` and `done_head` read 0x80 when their queue is empty. Otherwise they read the head page number.
- R12: After reset, `int_status` is 0x04, `int_mask` is 0, `alloc_result` is 0, and all queues and the bitmap are empty. Command 2 empties all queues and the bitmap and sets `alloc_result` to 0. It leaves the status bits as they are, apart from the R8 updates.
- R13: Opcode 0 is a no-op. A command is accepted in every cycle, and `mmu_busy` is always 0. `pages_used` equals the number of set bits in the used-page bitmap.
- R14: Command 5 frees the page given by `cmd_pnum`. It is ignored when `cmd_pnum` is not below NUM_PAGES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_pnum | input | 8 | Current packet page number |
| auto_release | input | 1 | Free sent pages instead of reporting them |
| rx_req | input | 1 | Receive engine asks for a page |
| rx_grant | output | 1 | Receive request accepted this cycle |
| rx_page | output | 8 | Page granted to the receiver, 0x80 if none |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_page | output | 8 | Page at the head of the transmit queue |
| tx_done | input | 1 | Transmit engine finished the head page |
| ack_we | input | 1 | Interrupt acknowledge strobe |
| ack_data | input | 8 | Status bits to clear |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_data | input | 8 | New interrupt mask |
| alloc_result | output | 8 | Last transmit allocation result |
| rx_head | output | 8 | Head of the receive queue, 0x80 if empty |
| done_head | output | 8 | Head of the completion queue, 0x80 if empty |
| pages_used | output | $clog2(NUM_PAGES+1) | Number of used pages |
| int_status | output | 8 | Interrupt status byte |
| int_mask | output | 8 | Interrupt mask byte |
| mmu_busy | output | 1 | Busy flag, always 0 |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted bitmap appears on `pages_used` in the next cycle. It also shows up within one command as the wrong page in `alloc_result` or `rx_page`. A misordered queue shows up as a wrong `tx_page`, `rx_head` or `done_head` at the first pop that reaches the bad entry, which is at most NUM_PAGES pops later. Status bits that are missing or stale show in `int_status` one cycle after the event. They show on `irq` in the same cycle, as soon as the mask selects them. A retry that never fires leaves `alloc_result` at 0x80 after a release, so it is visible one cycle after the release.

// File: rtl/pkt_mmu_pkg.sv
package pkt_mmu_pkg;
   localparam logic [7:0] NO_PAGE      = 8'h80;
   localparam logic [7:0] ACK_CLR_MASK = 8'hD6;
   localparam logic [7:0] STATUS_RST   = 8'h04;
   localparam int BIT_RX     = 0;
   localparam int BIT_TXDONE = 1;
   localparam int BIT_TXIDLE = 2;
   localparam int BIT_ALLOC  = 3;

   typedef enum logic [2:0] {
      OP_NOP     = 3'd0,
      OP_TXALLOC = 3'd1,
      OP_MMURST  = 3'd2,
      OP_RXPOP   = 3'd3,
      OP_RXPOPRL = 3'd4,
      OP_RELEASE = 3'd5,
      OP_TXENQ   = 3'd6,
      OP_TXRST   = 3'd7
   } mmu_op_e;
endpackage

// File: rtl/pkt_mmu_lowfree.sv
module pkt_mmu_lowfree #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  used,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!used[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/pkt_mmu_popcnt.sv
module pkt_mmu_popcnt #(
   parameter int N = 4,
   localparam int CW = $clog2(N + 1)
) (
   input  logic [N-1:0]  bits,
   output logic [CW-1:0] cnt
);
   always_comb begin
      cnt = '0;
      for (int i = 0; i < N; i++) cnt = cnt + CW'(bits[i]);
   end
endmodule

// File: rtl/pkt_mmu_shiftq.sv
module pkt_mmu_shiftq #(
   parameter int DEPTH = 4,
   parameter int W     = 2,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count,
   output logic          occ_nxt
);
   logic [W-1:0]  q  [DEPTH];
   logic [W-1:0]  qn [DEPTH];
   logic [CW-1:0] cn;

   // pop first, then push into the freed slot, clear wins over both
   always_comb begin
      qn = q;
      cn = count;
      if (pop && count != '0) begin
         for (int i = 0; i < DEPTH - 1; i++) qn[i] = q[i + 1];
         qn[DEPTH-1] = '0;
         cn = count - CW'(1);
      end
      if (push && cn != CW'(DEPTH)) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) == cn) qn[i] = din;
         end
         cn = cn + CW'(1);
      end
      if (clr) cn = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         for (int i = 0; i < DEPTH; i++) q[i] <= '0;
      end else begin
         count <= cn;
         q     <= qn;
      end
   end

   assign head    = q[0];
   assign occ_nxt = (cn != '0);
endmodule

// File: rtl/pkt_mmu.sv
module pkt_mmu
   import pkt_mmu_pkg::*;
#(
   parameter int NUM_PAGES = 4,
   localparam int CNT_W    = $clog2(NUM_PAGES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [2:0]       cmd_op,
   input  logic [7:0]       cmd_pnum,
   input  logic             auto_release,
   input  logic             rx_req,
   output logic             rx_grant,
   output logic [7:0]       rx_page,
   output logic             tx_valid,
   output logic [7:0]       tx_page,
   input  logic             tx_done,
   input  logic             ack_we,
   input  logic [7:0]       ack_data,
   input  logic             mask_we,
   input  logic [7:0]       mask_data,
   output logic [7:0]       alloc_result,
   output logic [7:0]       rx_head,
   output logic [7:0]       done_head,
   output logic [CNT_W-1:0] pages_used,
   output logic [7:0]       int_status,
   output logic [7:0]       int_mask,
   output logic             mmu_busy,
   output logic             irq
);
   localparam int IDX_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

   if (NUM_PAGES < 2 || NUM_PAGES > 128) begin : g_bad_pages
      $error("pkt_mmu: NUM_PAGES must lie in 2..128");
   end

   mmu_op_e op;
   assign op = mmu_op_e'(cmd_op);

   logic do_txalloc, do_mmurst, do_rxpop, do_rxpoprl, do_release, do_txenq, do_txrst;
   assign do_txalloc = cmd_valid && op == OP_TXALLOC;
   assign do_mmurst  = cmd_valid && op == OP_MMURST;
   assign do_rxpop   = cmd_valid && op == OP_RXPOP;
   assign do_rxpoprl = cmd_valid && op == OP_RXPOPRL;
   assign do_release = cmd_valid && op == OP_RELEASE;
   assign do_txenq   = cmd_valid && op == OP_TXENQ;
   assign do_txrst   = cmd_valid && op == OP_TXRST;

   logic pnum_ok;
   assign pnum_ok = cmd_pnum < 8'(NUM_PAGES);

   logic [NUM_PAGES-1:0] used_q, used_n, used_b, grant_oh, rel_oh;
   logic [7:0]           res_q, res_n, res_a, st_q, st_n, mask_q;

   // queue wires
   logic [IDX_W-1:0] txq_head, rxq_head, dq_head;
   logic [CNT_W-1:0] txq_cnt, rxq_cnt, dq_cnt;
   logic             txq_occ_nxt, rxq_occ_nxt, dq_occ_nxt;

   // receive grant is judged on the used pages at the start of the cycle
   logic             rx_free_ok;
   logic [IDX_W-1:0] rx_free_idx;
   pkt_mmu_lowfree #(.N(NUM_PAGES)) u_rx_find (
      .used(used_q), .found(rx_free_ok), .idx(rx_free_idx));

   assign rx_grant = rx_req && rx_free_ok && !do_mmurst;
   assign rx_page  = rx_grant ? 8'(rx_free_idx) : NO_PAGE;
   assign grant_oh = rx_grant ? (NUM_PAGES'(1) << rx_free_idx) : '0;

   logic tx_fire;
   assign tx_fire = tx_done && txq_cnt != '0;

   always_comb begin
      rel_oh = '0;
      if (tx_fire && auto_release)          rel_oh[txq_head]             = 1'b1;
      if (do_rxpoprl && rxq_cnt != '0)      rel_oh[rxq_head]             = 1'b1;
      if (do_release && pnum_ok)            rel_oh[cmd_pnum[IDX_W-1:0]]  = 1'b1;
   end

   assign used_b = (used_q | grant_oh) & ~rel_oh;

   logic             tx_free_ok;
   logic [IDX_W-1:0] tx_free_idx;
   pkt_mmu_lowfree #(.N(NUM_PAGES)) u_tx_find (
      .used(used_b), .found(tx_free_ok), .idx(tx_free_idx));

   // a result of NO_PAGE is a pending transmit allocation: it completes
   // as soon as a page is free, which only a release can bring about
   logic take;
   assign res_a = do_txalloc ? NO_PAGE : res_q;
   assign take  = (res_a == NO_PAGE) && tx_free_ok && !do_mmurst;

   always_comb begin
      used_n = take ? (used_b | (NUM_PAGES'(1) << tx_free_idx)) : used_b;
      res_n  = take ? 8'(tx_free_idx) : res_a;
      if (do_mmurst) begin
         used_n = '0;
         res_n  = 8'h00;
      end
   end

   always_comb begin
      st_n = st_q;
      if (ack_we)     st_n = st_n & ~(ack_data & ACK_CLR_MASK);
      if (do_txalloc) st_n[BIT_ALLOC] = 1'b0;
      if (take)       st_n[BIT_ALLOC] = 1'b1;
      if (do_rxpop || do_rxpoprl) st_n[BIT_RX] = rxq_occ_nxt;
      else if (rx_grant)          st_n[BIT_RX] = 1'b1;
      if (dq_occ_nxt)   st_n[BIT_TXDONE] = 1'b1;
      if (!txq_occ_nxt) st_n[BIT_TXIDLE] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         used_q <= '0;
         res_q  <= 8'h00;
         st_q   <= STATUS_RST;
         mask_q <= 8'h00;
      end else begin
         used_q <= used_n;
         res_q  <= res_n;
         st_q   <= st_n;
         if (mask_we) mask_q <= mask_data;
      end
   end

   pkt_mmu_shiftq #(.DEPTH(NUM_PAGES), .W(IDX_W)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(do_txrst || do_mmurst),
      .push(do_txenq && pnum_ok), .pop(tx_fire), .din(cmd_pnum[IDX_W-1:0]),
      .head(txq_head), .count(txq_cnt), .occ_nxt(txq_occ_nxt));

   pkt_mmu_shiftq #(.DEPTH(NUM_PAGES), .W(IDX_W)) u_doneq (
      .clk(clk), .rst_n(rst_n), .clr(do_txrst || do_mmurst),
      .push(tx_fire && !auto_release), .pop(ack_we && ack_data[BIT_TXDONE]),
      .din(txq_head), .head(dq_head), .count(dq_cnt), .occ_nxt(dq_occ_nxt));

   pkt_mmu_shiftq #(.DEPTH(NUM_PAGES), .W(IDX_W)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(do_mmurst),
      .push(rx_grant), .pop(do_rxpop || do_rxpoprl), .din(rx_free_idx),
      .head(rxq_head), .count(rxq_cnt), .occ_nxt(rxq_occ_nxt));

   pkt_mmu_popcnt #(.N(NUM_PAGES)) u_used_cnt (.bits(used_q), .cnt(pages_used));

   assign tx_valid     = txq_cnt != '0;
   assign tx_page      = 8'(txq_head);
   assign rx_head      = (rxq_cnt == '0) ? NO_PAGE : 8'(rxq_head);
   assign done_head    = (dq_cnt == '0) ? NO_PAGE : 8'(dq_head);
   assign alloc_result = res_q;
   assign int_status   = st_q;
   assign int_mask     = mask_q;
   assign mmu_busy     = 1'b0;
   assign irq          = |(st_q & mask_q);
endmodule

// File: rtl/pkt_mmu_chk.sv
module pkt_mmu_chk #(
   parameter int NUM_PAGES = 4,
   localparam int CNT_W    = $clog2(NUM_PAGES + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [2:0]       cmd_op,
   input logic             rx_req,
   input logic             rx_grant,
   input logic             tx_valid,
   input logic             ack_we,
   input logic             mask_we,
   input logic [7:0]       mask_data,
   input logic [7:0]       alloc_result,
   input logic [7:0]       rx_head,
   input logic [7:0]       done_head,
   input logic [CNT_W-1:0] pages_used,
   input logic [7:0]       int_status,
   input logic [7:0]       int_mask
);
   // full pool never grants a receive page
   p_full_no_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pages_used == CNT_W'(NUM_PAGES)) |-> !rx_grant);

   p_alloc_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd1 && pages_used < CNT_W'(NUM_PAGES) && !rx_req)
      |=> (alloc_result != 8'h80 && int_status[3]));

   p_rx_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_head != 8'h80) |-> int_status[0]);

   p_txidle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_valid |-> int_status[2]);

   p_txdone_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_head != 8'h80) |-> int_status[1]);

   p_ack_keeps_alloc_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && int_status[3] && !(cmd_valid && cmd_op == 3'd1)) |=> int_status[3]);

   p_mask_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |=> (int_mask == $past(mask_data)));

   p_used_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
      pages_used <= CNT_W'(NUM_PAGES));
endmodule

bind pkt_mmu pkt_mmu_chk #(.NUM_PAGES(NUM_PAGES)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .rx_req(rx_req), .rx_grant(rx_grant), .tx_valid(tx_valid),
   .ack_we(ack_we), .mask_we(mask_we), .mask_data(mask_data),
   .alloc_result(alloc_result), .rx_head(rx_head), .done_head(done_head),
   .pages_used(pages_used), .int_status(int_status), .int_mask(int_mask));

// File: tb/pkt_mmu_tb.sv
`timescale 1ns/1ps
module pkt_mmu_tb;
   localparam int NP = 4;
   localparam int CW = $clog2(NP + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid, rx_req, tx_done, auto_release, ack_we, mask_we;
   logic [2:0]    cmd_op;
   logic [7:0]    cmd_pnum, ack_data, mask_data;
   logic          rx_grant, tx_valid, mmu_busy, irq;
   logic [7:0]    rx_page, tx_page, alloc_result, rx_head, done_head, int_status, int_mask;
   logic [CW-1:0] pages_used;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   pkt_mmu #(.NUM_PAGES(NP)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_pnum(cmd_pnum), .auto_release(auto_release), .rx_req(rx_req),
      .rx_grant(rx_grant), .rx_page(rx_page), .tx_valid(tx_valid),
      .tx_page(tx_page), .tx_done(tx_done), .ack_we(ack_we), .ack_data(ack_data),
      .mask_we(mask_we), .mask_data(mask_data), .alloc_result(alloc_result),
      .rx_head(rx_head), .done_head(done_head), .pages_used(pages_used),
      .int_status(int_status), .int_mask(int_mask), .mmu_busy(mmu_busy), .irq(irq));

   typedef struct packed {
      logic       cv;
      logic [2:0] op;
      logic [7:0] pn;
      logic       rxr;
      logic       txd;
      logic       ar;
      logic       aw;
      logic [7:0] ad;
      logic [7:0] e_res;
      logic [7:0] e_rxh;
      logic [7:0] e_dnh;
      logic [7:0] e_txp;
      logic [2:0] e_used;
      logic [7:0] e_st;
      logic [3:0] rq;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{1'b1,3'd1,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h00,8'h80,8'h80,8'h80,3'd1,8'h0C,4'd1},  // R1 alloc page 0
      '{1'b1,3'd1,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h01,8'h80,8'h80,8'h80,3'd2,8'h0C,4'd2},  // R2 alloc page 1
      '{1'b0,3'd0,8'h00,1'b1,1'b0,1'b0,1'b0,8'h00, 8'h01,8'h02,8'h80,8'h80,3'd3,8'h0D,4'd4},  // R4 rx gets page 2
      '{1'b1,3'd6,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h01,8'h02,8'h80,8'h00,3'd3,8'h0D,4'd6},  // R6 enqueue 0
      '{1'b0,3'd0,8'h00,1'b0,1'b0,1'b0,1'b1,8'h04, 8'h01,8'h02,8'h80,8'h00,3'd3,8'h09,4'd10}, // R10 ack idle bit
      '{1'b0,3'd0,8'h00,1'b0,1'b1,1'b0,1'b0,8'h00, 8'h01,8'h02,8'h00,8'h80,3'd3,8'h0F,4'd7},  // R7 to completion
      '{1'b0,3'd0,8'h00,1'b0,1'b0,1'b0,1'b1,8'hFF, 8'h01,8'h02,8'h80,8'h80,3'd3,8'h0D,4'd10}, // R10 ack all, pop
      '{1'b0,3'd0,8'h00,1'b1,1'b0,1'b0,1'b0,8'h00, 8'h01,8'h02,8'h80,8'h80,3'd4,8'h0D,4'd4},  // R4 rx page 3
      '{1'b1,3'd1,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h80,8'h02,8'h80,8'h80,3'd4,8'h05,4'd2},  // R2 fail when full
      '{1'b0,3'd0,8'h00,1'b1,1'b0,1'b0,1'b0,8'h00, 8'h80,8'h02,8'h80,8'h80,3'd4,8'h05,4'd4},  // R4 rx dropped
      '{1'b1,3'd3,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h80,8'h03,8'h80,8'h80,3'd4,8'h05,4'd5},  // R5 pop keeps page
      '{1'b1,3'd4,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h03,8'h80,8'h80,8'h80,3'd4,8'h0C,4'd3},  // R3 retry takes page 3
      '{1'b1,3'd5,8'h02,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h03,8'h80,8'h80,8'h80,3'd3,8'h0C,4'd14}, // R14 release 2
      '{1'b1,3'd5,8'h09,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h03,8'h80,8'h80,8'h80,3'd3,8'h0C,4'd14}, // R14 out of range
      '{1'b1,3'd6,8'h01,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h03,8'h80,8'h80,8'h01,3'd3,8'h0C,4'd6},  // R6 enqueue 1
      '{1'b0,3'd0,8'h00,1'b0,1'b1,1'b1,1'b0,8'h00, 8'h03,8'h80,8'h80,8'h80,3'd2,8'h0C,4'd7},  // R7 auto release
      '{1'b1,3'd6,8'h07,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h03,8'h80,8'h80,8'h80,3'd2,8'h0C,4'd6},  // R6 bad page ignored
      '{1'b1,3'd2,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h00,8'h80,8'h80,8'h80,3'd0,8'h0C,4'd12}  // R12 mmu reset
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      cmd_valid = 1'b0; cmd_op = 3'd0; cmd_pnum = 8'h00; rx_req = 1'b0;
      tx_done = 1'b0; auto_release = 1'b0; ack_we = 1'b0; ack_data = 8'h00;
      mask_we = 1'b0; mask_data = 8'h00;
   endtask

   // inputs set at a falling edge, one rising edge passes, outputs read at the next fall
   task automatic step();
      @(negedge clk);
      idle();
   endtask

   task automatic cmd(input logic [2:0] op, input logic [7:0] pn);
      cmd_valid = 1'b1; cmd_op = op; cmd_pnum = pn;
      step();
   endtask

   task automatic ack(input logic [7:0] d);
      ack_we = 1'b1; ack_data = d;
      step();
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12 R11 R13 reset state
      chk("R12 status", 32'(int_status), 32'h04);
      chk("R12 mask", 32'(int_mask), 32'h00);
      chk("R12 result", 32'(alloc_result), 32'h00);
      chk("R13 used", 32'(pages_used), 32'h0);
      chk("R11 rx head", 32'(rx_head), 32'h80);
      chk("R11 done head", 32'(done_head), 32'h80);
      chk("R6 tx valid", 32'(tx_valid), 32'h0);
      chk("R13 busy", 32'(mmu_busy), 32'h0);
      chk("R9 irq", 32'(irq), 32'h0);

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         v = VECS[i];
         cmd_valid = v.cv; cmd_op = v.op; cmd_pnum = v.pn; rx_req = v.rxr;
         tx_done = v.txd; auto_release = v.ar; ack_we = v.aw; ack_data = v.ad;
         step();
         chk($sformatf("R%0d vec %0d result", v.rq, i), 32'(alloc_result), 32'(v.e_res));
         chk($sformatf("R%0d vec %0d rx head", v.rq, i), 32'(rx_head), 32'(v.e_rxh));
         chk($sformatf("R%0d vec %0d done head", v.rq, i), 32'(done_head), 32'(v.e_dnh));
         chk($sformatf("R%0d vec %0d tx head", v.rq, i), tx_valid ? 32'(tx_page) : 32'h80, 32'(v.e_txp));
         chk($sformatf("R%0d vec %0d used", v.rq, i), 32'(pages_used), 32'(v.e_used));
         chk($sformatf("R%0d vec %0d status", v.rq, i), 32'(int_status), 32'(v.e_st));
      end

      // R9 mask selects the interrupt line (status is 0x0C here)
      mask_we = 1'b1; mask_data = 8'h08; step();
      chk("R9 mask value", 32'(int_mask), 32'h08);
      chk("R9 irq on", 32'(irq), 32'h1);
      mask_we = 1'b1; mask_data = 8'h01; step();
      chk("R9 irq off", 32'(irq), 32'h0);

      // R6 transmit queue holds NUM_PAGES, the fifth enqueue is ignored
      for (int k = 0; k < NP; k++) cmd(3'd6, 8'(k));
      cmd(3'd6, 8'h00);
      for (int k = 0; k < NP; k++) begin
         chk("R6 tx order", 32'(tx_page), 32'(k));
         tx_done = 1'b1; step();
      end
      chk("R6 full enqueue ignored", 32'(tx_valid), 32'h0);
      chk("R7 completion head", 32'(done_head), 32'h00);
      cmd(3'd7, 8'h00);
      chk("R6 tx reset clears completion", 32'(done_head), 32'h80);

      // R7 completion queue drops a fifth entry
      ack(8'h02);
      for (int k = 0; k < NP + 1; k++) begin
         cmd(3'd6, 8'h00);
         tx_done = 1'b1; step();
      end
      for (int k = 0; k < NP - 1; k++) ack(8'h02);
      chk("R7 one entry left", 32'(done_head), 32'h00);
      chk("R8 sent bit held", 32'(int_status[1]), 32'h1);
      ack(8'h02);
      chk("R7 fifth entry dropped", 32'(done_head), 32'h80);
      chk("R8 sent bit cleared", 32'(int_status[1]), 32'h0);

      // R4 same-cycle grant of the lowest free page
      rx_req = 1'b1;
      #1;
      chk("R4 grant", 32'(rx_grant), 32'h1);
      chk("R4 page", 32'(rx_page), 32'h00);
      step();
      chk("R4 queued", 32'(rx_head), 32'h00);
      chk("R5 receive bit", 32'(int_status[0]), 32'h1);

      report();
   end
endmodule